// File: doc/BRIEF.md
# Strided Vector Prefetch Engine

This engine belongs to one processor. It fetches one strided vector from global memory into a local 512-word buffer, with a mask that can drop single elements. Software first arms it with an element count, a signed stride and an element mask. A physical start address then fires it. That address may come from a dedicated prefetch command or from the first address of a vector load. The engine then walks the vector and issues one read request per enabled element. Each request is tagged with its element index.

Replies can come back from the network in any order. Each reply is written to the buffer word named by its tag, and that word's full bit is set. The processor reads words by index, in whatever order it likes, while the fetch is still running. A word that has not arrived yet answers not-ready, and the reader stalls until it fills. The engine deals only in physical addresses. Before stepping into a new 4 KB page it suspends and waits until the processor supplies the physical address of the next element. The buffer keeps its contents after the fetch has finished, until the next fire.

Top module: `vec_prefetch_engine`

## Requirements
- R1: After reset the engine is idle (`busy`=0), not suspended, issues no request, and every buffer word reads not-ready.
- R2: An arm pulse while idle latches length, stride and mask. An arm pulse while busy has no effect on the running fetch.
- R3: A fire pulse while idle starts a fetch at `fireAddr` and invalidates every buffer word in the cycle after the pulse. A fire pulse while requests are being issued has no effect.
- R4: Element i+1 lies at the address of element i plus stride×8 bytes, where stride is a signed two's-complement element count. Requests carry the element index as tag, in ascending order. A request holds its address and tag until `reqReady` accepts it.
- R5: Bit i of `armMask` enables element i. A disabled element is never requested. Its word reads ready with `rdSkipped`=1.
- R6: Suppose the next element's address lies in a different 4096-byte page and elements remain. The engine then raises `suspended` and issues nothing until a `fireValid` pulse. The `fireAddr` of that pulse becomes the next element's address.
- R7: With no page crossing, all mask bits set and `reqReady` held high, the engine issues all requests on consecutive cycles, one per cycle.
- R8: A reply stores `rspData` in the word indexed by `rspTag` and marks that word full, whatever order the replies arrive in.
- R9: `rdReady` is 1 only when `rdValid` is 1 and word `rdIdx` is full. Unreturned words and words beyond the length read not-ready.
- R10: Buffer contents stay readable after the fetch completes, until the next fire.
- R11: A length of 0 completes at once with no request. A length above 512 is treated as 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armValid | input | 1 | Arm pulse |
| armLen | input | 10 | Element count |
| armStride | input | 16 | Signed stride in 8-byte words |
| armMask | input | 512 | Per-element enable mask |
| fireValid | input | 1 | Start pulse, or resume pulse while suspended |
| fireAddr | input | 32 | Physical byte address for start or resume |
| reqValid | output | 1 | Read request valid |
| reqReady | input | 1 | Network accepts request |
| reqAddr | output | 32 | Request physical address |
| reqTag | output | 9 | Request element index |
| rspValid | input | 1 | Reply valid |
| rspTag | input | 9 | Reply element index |
| rspData | input | 64 | Reply data |
| rdValid | input | 1 | Processor read strobe |
| rdIdx | input | 9 | Buffer word to read |
| rdReady | output | 1 | Read word is full |
| rdData | output | 64 | Read word data |
| rdSkipped | output | 1 | Read word was masked off |
| busy | output | 1 | Fetch in progress |
| suspended | output | 1 | Waiting for a new-page address |

## Verification
The bench sweeps strides of both signs, including zero, from start addresses just below a page end. This catches an engine that steps the wrong direction, misses a crossing or fails to resume at the supplied address; such an engine shows up as a request address mismatch or a wrong suspension count. Replies are returned reversed and interleaved. After the first reply it probes a word that has not been returned yet, so a design that marks words full on request, or writes by arrival order, reads wrong data or reports ready too early. Disabled elements, length zero, a length above 512 and stray arm and fire pulses during a fetch are each driven. A design that requests masked words, fails to clamp, or restarts on a stray pulse produces a wrong request count or wrong addresses.

// File: rtl/vpf_pkg.sv
`timescale 1ns/1ps
package vpf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_PAUSE = 2'd2
  } vpfState_t;

  // Strobes from control to the buffer datapath
  typedef struct packed {
    logic clearAll;   // invalidate every word
    logic skipMark;   // mark the current element full and skipped
  } vpfCtl_t;
endpackage

// File: rtl/vpf_ctrl.sv
`timescale 1ns/1ps
module vpf_ctrl
  import vpf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DEPTH      = 512,
  parameter int STRIDE_W   = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int WORD_BYTES = 8,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int LEN_W     = IDX_W + 1,
  localparam int PAGE_SH   = $clog2(PAGE_BYTES),
  localparam int WORD_SH   = $clog2(WORD_BYTES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       armValid,
  input  logic [LEN_W-1:0]           armLen,
  input  logic signed [STRIDE_W-1:0] armStride,
  input  logic [DEPTH-1:0]           armMask,
  input  logic                       fireValid,
  input  logic [ADDR_W-1:0]          fireAddr,
  output logic                       reqValid,
  input  logic                       reqReady,
  output logic [ADDR_W-1:0]          reqAddr,
  output logic [IDX_W-1:0]           reqTag,
  output vpfCtl_t                    ctl,
  output logic [IDX_W-1:0]           skipIdx,
  output logic                       busy,
  output logic                       suspended
);
  vpfState_t                stateQ;
  logic [LEN_W-1:0]         lenQ;
  logic [LEN_W-1:0]         idxQ;
  logic signed [STRIDE_W-1:0] strideQ;
  logic [DEPTH-1:0]         maskQ;
  logic [ADDR_W-1:0]        addrQ;

  logic [IDX_W-1:0]  elem;
  logic              remaining;
  logic              wanted;
  logic              issuing;
  logic              advance;
  logic              moreAfter;
  logic              crossing;
  logic [ADDR_W-1:0] stepBytes;
  logic [ADDR_W-1:0] nextAddr;
  logic [LEN_W-1:0]  lenIn;

  assign elem      = idxQ[IDX_W-1:0];
  assign remaining = (idxQ != lenQ);
  assign wanted    = maskQ[elem];
  assign issuing   = (stateQ == ST_ISSUE) && remaining;
  assign advance   = issuing && (!wanted || reqReady);
  assign moreAfter = ((idxQ + LEN_W'(1)) != lenQ);

  assign stepBytes = {{(ADDR_W-STRIDE_W){strideQ[STRIDE_W-1]}}, strideQ} << WORD_SH;
  assign nextAddr  = addrQ + stepBytes;
  assign crossing  = (nextAddr[ADDR_W-1:PAGE_SH] != addrQ[ADDR_W-1:PAGE_SH]);

  assign lenIn = (armLen > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : armLen;

  assign reqValid  = issuing && wanted;
  assign reqAddr   = addrQ;
  assign reqTag    = elem;
  assign skipIdx   = elem;
  assign busy      = (stateQ != ST_IDLE);
  assign suspended = (stateQ == ST_PAUSE);

  always_comb begin
    ctl          = '0;
    ctl.clearAll = (stateQ == ST_IDLE) && fireValid;
    ctl.skipMark = issuing && !wanted;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      lenQ    <= '0;
      idxQ    <= '0;
      strideQ <= '0;
      maskQ   <= '0;
      addrQ   <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (armValid) begin
            lenQ    <= lenIn;
            strideQ <= armStride;
            maskQ   <= armMask;
          end
          if (fireValid) begin
            addrQ  <= fireAddr;
            idxQ   <= '0;
            stateQ <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (!remaining) begin
            stateQ <= ST_IDLE;
          end else if (advance) begin
            idxQ  <= idxQ + LEN_W'(1);
            addrQ <= nextAddr;
            if (moreAfter && crossing) stateQ <= ST_PAUSE;
          end
        end
        ST_PAUSE: begin
          if (fireValid) begin
            addrQ  <= fireAddr;
            stateQ <= ST_ISSUE;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vpf_data.sv
`timescale 1ns/1ps
module vpf_data
  import vpf_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  vpfCtl_t           ctl,
  input  logic [IDX_W-1:0]  skipIdx,
  input  logic              rspValid,
  input  logic [IDX_W-1:0]  rspTag,
  input  logic [DATA_W-1:0] rspData,
  input  logic              rdValid,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdReady,
  output logic [DATA_W-1:0] rdData,
  output logic              rdSkipped
);
  logic [DATA_W-1:0] memQ [DEPTH];
  logic [DEPTH-1:0]  fullQ;
  logic [DEPTH-1:0]  skipQ;

  always_ff @(posedge clk) begin
    if (rspValid) memQ[rspTag] <= rspData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullQ <= '0;
      skipQ <= '0;
    end else if (ctl.clearAll) begin
      fullQ <= '0;
      skipQ <= '0;
    end else begin
      if (ctl.skipMark) begin
        fullQ[skipIdx] <= 1'b1;
        skipQ[skipIdx] <= 1'b1;
      end
      if (rspValid) fullQ[rspTag] <= 1'b1;
    end
  end

  assign rdReady   = rdValid && fullQ[rdIdx];
  assign rdData    = memQ[rdIdx];
  assign rdSkipped = skipQ[rdIdx];
endmodule

// File: rtl/vec_prefetch_engine.sv
`timescale 1ns/1ps
module vec_prefetch_engine
  import vpf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 64,
  parameter int DEPTH      = 512,
  parameter int STRIDE_W   = 16,
  parameter int PAGE_BYTES = 4096,
  parameter int WORD_BYTES = 8,
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int LEN_W     = IDX_W + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       armValid,
  input  logic [LEN_W-1:0]           armLen,
  input  logic signed [STRIDE_W-1:0] armStride,
  input  logic [DEPTH-1:0]           armMask,
  input  logic                       fireValid,
  input  logic [ADDR_W-1:0]          fireAddr,
  output logic                       reqValid,
  input  logic                       reqReady,
  output logic [ADDR_W-1:0]          reqAddr,
  output logic [IDX_W-1:0]           reqTag,
  input  logic                       rspValid,
  input  logic [IDX_W-1:0]           rspTag,
  input  logic [DATA_W-1:0]          rspData,
  input  logic                       rdValid,
  input  logic [IDX_W-1:0]           rdIdx,
  output logic                       rdReady,
  output logic [DATA_W-1:0]          rdData,
  output logic                       rdSkipped,
  output logic                       busy,
  output logic                       suspended
);
  vpfCtl_t          ctl;
  logic [IDX_W-1:0] skipIdx;

  vpf_ctrl #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .STRIDE_W(STRIDE_W),
    .PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .armValid(armValid), .armLen(armLen), .armStride(armStride), .armMask(armMask),
    .fireValid(fireValid), .fireAddr(fireAddr),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr), .reqTag(reqTag),
    .ctl(ctl), .skipIdx(skipIdx), .busy(busy), .suspended(suspended)
  );

  vpf_data #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .ctl(ctl), .skipIdx(skipIdx),
    .rspValid(rspValid), .rspTag(rspTag), .rspData(rspData),
    .rdValid(rdValid), .rdIdx(rdIdx),
    .rdReady(rdReady), .rdData(rdData), .rdSkipped(rdSkipped)
  );
endmodule

// File: rtl/vpf_checker.sv
`timescale 1ns/1ps
module vpf_checker #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              suspended,
  input logic              fireValid,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [IDX_W-1:0]  reqTag,
  input logic              rdValid,
  input logic              rdReady
);
  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqTag)); // R4
  AST_TAG_ASCENDS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqValid || (reqTag > $past(reqTag))); // R4
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> !reqValid); // R6
  AST_RESUME: assert property (@(posedge clk) disable iff (!rstN)
    suspended && fireValid |=> !suspended && busy); // R6
  AST_FIRE_INVALIDATES: assert property (@(posedge clk) disable iff (!rstN)
    !busy && fireValid |=> !rdReady); // R3
  AST_READ_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    rdReady |-> rdValid); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !reqValid && !suspended); // R1
endmodule

bind vec_prefetch_engine vpf_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .suspended(suspended),
  .fireValid(fireValid), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .reqTag(reqTag), .rdValid(rdValid), .rdReady(rdReady)
);

// File: tb/sim_vec_prefetch_engine.sv
`timescale 1ns/1ps
module sim_vec_prefetch_engine;
  localparam int NW = 512;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              armValid = 1'b0;
  logic [9:0]        armLen = '0;
  logic signed [15:0] armStride = '0;
  logic [NW-1:0]     armMask = '0;
  logic              fireValid = 1'b0;
  logic [31:0]       fireAddr = '0;
  logic              reqValid;
  logic              reqReady = 1'b0;
  logic [31:0]       reqAddr;
  logic [8:0]        reqTag;
  logic              rspValid = 1'b0;
  logic [8:0]        rspTag = '0;
  logic [63:0]       rspData = '0;
  logic              rdValid = 1'b0;
  logic [8:0]        rdIdx = '0;
  logic              rdReady;
  logic [63:0]       rdData;
  logic              rdSkipped;
  logic              busy;
  logic              suspended;

  int nChecks = 0;
  int nFails  = 0;
  int runNo   = 0;
  int prevIdx = -1;
  logic [31:0] expAddr [NW];
  bit          expSusp [NW];
  int          accTag  [NW];
  int          ord     [NW];

  always #10 clk = ~clk;

  vec_prefetch_engine u0 (
    .clk(clk), .rstN(rstN), .armValid(armValid), .armLen(armLen),
    .armStride(armStride), .armMask(armMask), .fireValid(fireValid),
    .fireAddr(fireAddr), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqTag(reqTag), .rspValid(rspValid), .rspTag(rspTag),
    .rspData(rspData), .rdValid(rdValid), .rdIdx(rdIdx), .rdReady(rdReady),
    .rdData(rdData), .rdSkipped(rdSkipped), .busy(busy), .suspended(suspended)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h (run %0d)", req, act, exp, runNo);
    end
  endtask

  function automatic logic [63:0] dataOf(input int tag, input int run);
    return {32'(run), 23'd0, 9'(tag)};
  endfunction

  // Read one word away from the clock edge
  task automatic readWord(input int idx, output logic rdy, output logic [63:0] d, output logic sk);
    rdValid = 1'b1;
    rdIdx   = 9'(idx);
    #1;
    rdy = rdReady; d = rdData; sk = rdSkipped;
    rdValid = 1'b0;
  endtask

  task automatic runFetch(input logic [31:0] base, input int stride, input int len,
                          input int maskMode, input int readyMode, input int orderMode,
                          input bit disturb, input bit timeBurst);
    int effLen, nExp, nAcc, nSuspExp, nSuspSeen, suspPtr, nextElem, cyc, firstCyc, lastCyc;
    logic [NW-1:0] mk;
    logic [31:0] a, n, step;
    logic rdy, sk;
    logic [63:0] d;
    runNo++;
    effLen = (len > NW) ? NW : len;
    step = 32'(stride * 8);
    for (int i = 0; i < NW; i++) mk[i] = (maskMode == 0) ? 1'b1 : ((i % 3) != 0);
    nExp = 0; nSuspExp = 0; a = base;
    for (int i = 0; i < effLen; i++) begin
      expSusp[i] = 1'b0;
      if (i > 0) begin
        n = a + step;
        if (n[31:12] != a[31:12]) begin
          expSusp[i] = 1'b1;
          n = n ^ 32'h0010_0000;
          nSuspExp++;
        end
        a = n;
      end
      expAddr[i] = a;
      if (mk[i]) nExp++;
    end
    // arm, then fire
    @(negedge clk);
    armValid = 1'b1; armLen = 10'(len); armStride = 16'(stride); armMask = mk;
    @(negedge clk);
    armValid = 1'b0; fireValid = 1'b1; fireAddr = base;
    @(negedge clk);
    fireValid = 1'b0;
    if (prevIdx >= 0) begin
      readWord(prevIdx, rdy, d, sk);
      chk(rdy == 1'b0, "R3 old word invalid after fire", 64'(rdy), 64'd0);
    end
    nAcc = 0; nSuspSeen = 0; suspPtr = 1; nextElem = 0; cyc = 0; firstCyc = -1; lastCyc = 0;
    while (suspPtr < effLen && !expSusp[suspPtr]) suspPtr++;
    while (busy && cyc < 20000) begin
      logic r;
      r = (readyMode == 0) ? 1'b1 : ((cyc % 3) != 1);
      fireValid = 1'b0; armValid = 1'b0;
      if (suspended) begin
        chk(suspPtr < effLen, "R6 suspension expected", 64'(suspPtr), 64'(effLen));
        fireValid = 1'b1;
        fireAddr  = (suspPtr < effLen) ? expAddr[suspPtr] : 32'h0;
        nSuspSeen++;
        suspPtr++;
        while (suspPtr < effLen && !expSusp[suspPtr]) suspPtr++;
      end else if (disturb && cyc == 2) begin
        fireValid = 1'b1; fireAddr = 32'hDEAD_0000;
        armValid = 1'b1; armLen = 10'd3;
      end
      reqReady = r;
      if (reqValid && r) begin
        int et;
        et = nextElem;
        while (et < effLen && !mk[et]) et++;
        chk(int'(reqTag) == et, "R4 tag order", 64'(reqTag), 64'(et));
        chk(reqAddr == ((et < effLen) ? expAddr[et] : 32'h0), "R4 element address",
            64'(reqAddr), 64'((et < effLen) ? expAddr[et] : 32'h0));
        if (nAcc < NW) accTag[nAcc] = int'(reqTag);
        nAcc++;
        nextElem = int'(reqTag) + 1;
        if (firstCyc < 0) firstCyc = cyc;
        lastCyc = cyc;
      end
      @(negedge clk);
      cyc++;
    end
    fireValid = 1'b0; armValid = 1'b0; reqReady = 1'b0;
    chk(!busy, "R11 fetch completes", 64'(busy), 64'd0);
    chk(nAcc == nExp, "R2 R5 R11 request count", 64'(nAcc), 64'(nExp));
    chk(nSuspSeen == nSuspExp, "R6 suspension count", 64'(nSuspSeen), 64'(nSuspExp));
    if (timeBurst)
      chk((lastCyc - firstCyc + 1) == nAcc, "R7 back-to-back issue",
          64'(lastCyc - firstCyc + 1), 64'(nAcc));
    if (nAcc > NW) nAcc = NW;
    // reply order
    for (int k = 0; k < nAcc; k++) ord[k] = nAcc - 1 - k;
    if (orderMode == 1) begin
      int p;
      p = 0;
      for (int k = 0; k < nAcc; k += 2) begin ord[p] = k; p++; end
      for (int k = 1; k < nAcc; k += 2) begin ord[p] = k; p++; end
    end
    if (nAcc > 0) begin
      readWord(accTag[ord[0]], rdy, d, sk);
      chk(rdy == 1'b0, "R9 not ready before reply", 64'(rdy), 64'd0);
      rspValid = 1'b1; rspTag = 9'(accTag[ord[0]]); rspData = dataOf(accTag[ord[0]], runNo);
      @(negedge clk);
      rspValid = 1'b0;
      readWord(accTag[ord[0]], rdy, d, sk);
      chk(rdy == 1'b1 && d == dataOf(accTag[ord[0]], runNo), "R9 early read of first reply",
          d, dataOf(accTag[ord[0]], runNo));
      if (nAcc > 1) begin
        readWord(accTag[ord[nAcc-1]], rdy, d, sk);
        chk(rdy == 1'b0, "R9 unreturned word not ready", 64'(rdy), 64'd0);
      end
      for (int k = 1; k < nAcc; k++) begin
        rspValid = 1'b1; rspTag = 9'(accTag[ord[k]]); rspData = dataOf(accTag[ord[k]], runNo);
        @(negedge clk);
      end
      rspValid = 1'b0;
    end
    @(negedge clk);
    for (int i = 0; i < effLen; i++) begin
      readWord(i, rdy, d, sk);
      if (mk[i]) begin
        chk(rdy == 1'b1 && d == dataOf(i, runNo) && sk == 1'b0, "R8 word data by tag",
            d, dataOf(i, runNo));
      end else begin
        chk(rdy == 1'b1 && sk == 1'b1, "R5 masked word skipped", {62'd0, rdy, sk}, 64'd3);
      end
    end
    if (effLen < NW) begin
      readWord(effLen, rdy, d, sk);
      chk(rdy == 1'b0, "R9 word past length not ready", 64'(rdy), 64'd0);
    end
    prevIdx = -1;
    for (int i = effLen - 1; i >= 0; i--) if (mk[i]) prevIdx = i;
    repeat (4) @(negedge clk);
    if (prevIdx >= 0) begin
      readWord(prevIdx, rdy, d, sk);
      chk(rdy == 1'b1 && d == dataOf(prevIdx, runNo), "R10 data kept after completion",
          d, dataOf(prevIdx, runNo));
    end
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic rdy, sk;
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !suspended && !reqValid, "R1 idle after reset",
        {61'd0, busy, suspended, reqValid}, 64'd0);
    readWord(0, rdy, d, sk);
    chk(rdy == 1'b0, "R1 buffer empty after reset", 64'(rdy), 64'd0);

    runFetch(32'h0000_1000,  1, 16, 0, 0, 0, 1'b0, 1'b1);
    runFetch(32'h0000_1FE0,  1, 12, 1, 0, 1, 1'b0, 1'b0);
    runFetch(32'h0000_3010, -1,  8, 0, 1, 0, 1'b1, 1'b0);
    runFetch(32'h0000_0000, 300, 10, 0, 1, 1, 1'b0, 1'b0);
    runFetch(32'h0004_0000,  0, 600, 0, 0, 1, 1'b0, 1'b1);
    runFetch(32'h0000_2000,  2,  0, 0, 0, 0, 1'b0, 1'b0);
    for (int s = -3; s <= 3; s++)
      runFetch(32'h0000_7FB0, s, 20, (s < 0) ? 1 : 0, (s % 2 == 0) ? 0 : 1, s & 1, 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule